// File: doc/BRIEF.md
# Bus Error Status Capture

This block gathers error events reported by a processor's memory interface into two sticky status registers. One register holds the synchronous class of errors; the other holds asynchronous errors, which come from DMA traffic and cache writebacks. Each event strobe carries the virtual address involved, and that address is kept in an address register paired with the status register of the same class.

Software reads the four registers through a small read port. Reading a status register returns its accumulated bits and clears them. Reading an address register changes nothing. Every asynchronous error is also recorded in the synchronous status register at the same bit position. An interrupt line stays high while any asynchronous status bit is set. Events are taken as they arrive and are never filtered, because speculative fetches can raise error bits for accesses that never retire.

Top module: `buserr_capture`

## Requirements
- R1: The synchronous status register keeps only bits 15 (write access), 7 (invalid entry), 6 (protection), 5 (timeout), 4 (bus error), 3 (memory ECC/parity), 1 (size error) and 0 (watchdog) of `sync_ev`. Any other bit of `sync_ev` has no effect and reads as 0.
- R2: Status bits are sticky. A new event ORs into the bits already held, and a held bit stays set until its register is read.
- R3: A read of a status register clears all of that register's bits at the clock edge where the read is sampled. It leaves the other status register unchanged.
- R4: The asynchronous status register keeps only bits 7 (writeback to invalid entry), 5 (timeout) and 4 (DMA bus error) of `async_ev`. Any other bit has no effect and reads as 0.
- R5: Each kept asynchronous event bit is also set at the same position in the synchronous status register.
- R6: `rd_sel` selects the register: 0 = sync status (offset 0x0), 1 = sync address (0x4), 2 = async status (0x8), 3 = async address (0xC). An address register loads `sync_vaddr` or `async_vaddr` on a cycle in which its class has at least one kept event bit.
- R7: Address registers keep their value across reads and across cycles with no kept event of their class. An asynchronous event does not change the sync address register.
- R8: When an event and a read of the same status register fall in one cycle, `rd_data` shows the value held before that cycle. After the edge, only the new event bits remain.
- R9: `irq` is high exactly when the asynchronous status register holds any bit. It goes low the cycle after an async-status read that has no simultaneous asynchronous event.
- R10: After reset, all four registers read 0 and `irq` is low.
- R11: `rd_data` is combinational from the held registers while `rd_en` is high, and it is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_ev | input | 16 | One-cycle synchronous error flags, in register bit positions |
| sync_vaddr | input | ADDR_W | Virtual address of the synchronous error |
| async_ev | input | 8 | One-cycle asynchronous error flags, in register bit positions |
| async_vaddr | input | ADDR_W | Virtual address of the asynchronous error |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register select (word offset bits 3:2) |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Asynchronous error pending |

## Verification
A vector table applies single flags, several flags at once, and flags with undefined positions set. These separate correct accumulation from overwrite and show that masking happens per bit. Asynchronous-only events that are then read back from the synchronous register show the mirroring, and reads of address registers between status reads show that the addresses survive clears. Directed cases place an event in the same cycle as a read of its register and read one register while the other holds bits. These distinguish clear-then-set from set-then-clear and a per-register clear from a global one. The interrupt is followed through an event, a plain read and a read that collides with an event.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
    localparam int SYNC_W  = 16;
    localparam int ASYNC_W = 8;
    localparam int DATA_W  = 32;

    // kept positions: write, invalid, protect, timeout, buserr, mem, size, watchdog
    localparam logic [SYNC_W-1:0]  SYNC_KEEP  = 16'h80FB;
    // kept positions: writeback-invalid, timeout, dma bus error
    localparam logic [ASYNC_W-1:0] ASYNC_KEEP = 8'hB0;

    typedef enum logic [1:0] {
        SEL_SYNC_STAT  = 2'd0,
        SEL_SYNC_ADDR  = 2'd1,
        SEL_ASYNC_STAT = 2'd2,
        SEL_ASYNC_ADDR = 2'd3
    } regsel_e;
endpackage

// File: rtl/buserr_sticky.sv
module buserr_sticky #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] set_kept;

    always_comb begin
        set_kept   = set_i & KEEP;
        st_d       = st_q;
        // clear applies to old contents only; same-cycle events survive
        st_d.stat  = (clr_i ? '0 : st_q.stat) | set_kept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ((set_i & KEEP) == '0)) |=> (stat_o == '0));

    p_event_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & KEEP) != '0) |=> ((stat_o & $past(set_i & KEEP)) == $past(set_i & KEEP)));
endmodule

// File: rtl/buserr_addr_hold.sv
module buserr_addr_hold #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) st_d.addr = addr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    p_addr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (addr_o == $past(addr_i)));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(addr_o));
endmodule

// File: rtl/buserr_rdmux.sv
module buserr_rdmux
    import buserr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               rd_en_i,
    input  logic [1:0]         rd_sel_i,
    input  logic [SYNC_W-1:0]  sync_stat_i,
    input  logic [AW-1:0]      sync_addr_i,
    input  logic [ASYNC_W-1:0] async_stat_i,
    input  logic [AW-1:0]      async_addr_i,
    output logic [DATA_W-1:0]  data_o,
    output logic               clr_sync_o,
    output logic               clr_async_o
);
    regsel_e sel;

    always_comb begin
        sel         = regsel_e'(rd_sel_i);
        data_o      = '0;
        clr_sync_o  = 1'b0;
        clr_async_o = 1'b0;
        if (rd_en_i) begin
            unique case (sel)
                SEL_SYNC_STAT: begin
                    data_o     = DATA_W'(sync_stat_i);
                    clr_sync_o = 1'b1;
                end
                SEL_SYNC_ADDR:  data_o = DATA_W'(sync_addr_i);
                SEL_ASYNC_STAT: begin
                    data_o      = DATA_W'(async_stat_i);
                    clr_async_o = 1'b1;
                end
                SEL_ASYNC_ADDR: data_o = DATA_W'(async_addr_i);
                default:        data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
    import buserr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SYNC_W-1:0]  sync_ev,
    input  logic [ADDR_W-1:0]  sync_vaddr,
    input  logic [ASYNC_W-1:0] async_ev,
    input  logic [ADDR_W-1:0]  async_vaddr,
    input  logic               rd_en,
    input  logic [1:0]         rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);
    localparam int PAD_W = SYNC_W - ASYNC_W;

    logic [SYNC_W-1:0]  sync_set, sync_stat;
    logic [ASYNC_W-1:0] async_kept, async_stat;
    logic [ADDR_W-1:0]  sync_addr, async_addr;
    logic               sync_ld, async_ld, clr_sync, clr_async;

    always_comb begin
        async_kept = async_ev & ASYNC_KEEP;
        // asynchronous errors also land in the synchronous register
        sync_set   = (sync_ev & SYNC_KEEP) | {{PAD_W{1'b0}}, async_kept};
        sync_ld    = |(sync_ev & SYNC_KEEP);
        async_ld   = |async_kept;
    end

    buserr_sticky #(.W(SYNC_W), .KEEP(SYNC_KEEP)) i_sync_stat (
        .clk(clk), .rst_n(rst_n), .set_i(sync_set), .clr_i(clr_sync), .stat_o(sync_stat)
    );

    buserr_sticky #(.W(ASYNC_W), .KEEP(ASYNC_KEEP)) i_async_stat (
        .clk(clk), .rst_n(rst_n), .set_i(async_ev), .clr_i(clr_async), .stat_o(async_stat)
    );

    buserr_addr_hold #(.AW(ADDR_W)) i_sync_addr (
        .clk(clk), .rst_n(rst_n), .ld_i(sync_ld), .addr_i(sync_vaddr), .addr_o(sync_addr)
    );

    buserr_addr_hold #(.AW(ADDR_W)) i_async_addr (
        .clk(clk), .rst_n(rst_n), .ld_i(async_ld), .addr_i(async_vaddr), .addr_o(async_addr)
    );

    buserr_rdmux #(.AW(ADDR_W)) i_rdmux (
        .rd_en_i(rd_en), .rd_sel_i(rd_sel),
        .sync_stat_i(sync_stat), .sync_addr_i(sync_addr),
        .async_stat_i(async_stat), .async_addr_i(async_addr),
        .data_o(rd_data), .clr_sync_o(clr_sync), .clr_async_o(clr_async)
    );

    assign irq = |async_stat;

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(async_ev & ASYNC_KEEP)) |=>
        ((sync_stat & {{PAD_W{1'b0}}, $past(async_ev & ASYNC_KEEP)}) ==
         {{PAD_W{1'b0}}, $past(async_ev & ASYNC_KEEP)}));

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(async_ev & ASYNC_KEEP)) |=> irq);

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd2 && ((async_ev & ASYNC_KEEP) == '0)) |=> !irq);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
endmodule

// File: tb/test_buserr_capture.sv
module test_buserr_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sync_ev = '0;
    logic [31:0] sync_vaddr = '0;
    logic [7:0]  async_ev = '0;
    logic [31:0] async_vaddr = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    buserr_capture i_buserr_capture (
        .clk(clk), .rst_n(rst_n), .sync_ev(sync_ev), .sync_vaddr(sync_vaddr),
        .async_ev(async_ev), .async_vaddr(async_vaddr), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] sev;
        logic [7:0]  aev;
        logic [31:0] sa;
        logic [31:0] aa;
        logic [1:0]  sel;
        logic [31:0] exp;
    } vec_t;

    // one event pulse, then a read; state carries across rows
    localparam vec_t VEC [0:12] = '{
        '{16'h0080, 8'h00, 32'h1000, 32'h0, 2'd0, 32'h0080},   // R1 single
        '{16'h8040, 8'h00, 32'h2000, 32'h0, 2'd1, 32'h2000},   // R6 sync addr
        '{16'h0001, 8'h00, 32'h3000, 32'h0, 2'd0, 32'h8041},   // R2 accumulate
        '{16'h0F0A, 8'h00, 32'h4000, 32'h0, 2'd0, 32'h000A},   // R1 masking
        '{16'h0000, 8'h20, 32'h0,    32'hA000, 2'd2, 32'h0020},// R4 async
        '{16'h0000, 8'h00, 32'h0,    32'h0, 2'd0, 32'h0020},   // R5 mirror
        '{16'h0000, 8'hFF, 32'h0,    32'hB000, 2'd3, 32'hB000},// R6 async addr
        '{16'h0000, 8'h00, 32'h0,    32'h0, 2'd2, 32'h00B0},   // R4 mask
        '{16'h0000, 8'h00, 32'h0,    32'h0, 2'd0, 32'h00B0},   // R5 mirror all
        '{16'h0000, 8'h00, 32'h0,    32'h0, 2'd1, 32'h4000},   // R7 addr kept
        '{16'h0000, 8'h10, 32'h0,    32'hC000, 2'd3, 32'hC000},// R6
        '{16'h0000, 8'h00, 32'h0,    32'h0, 2'd2, 32'h0010},   // R3 prior read cleared
        '{16'h0000, 8'h00, 32'h0,    32'h0, 2'd0, 32'h0010}    // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] sev, input logic [7:0] aev,
                         input logic [31:0] sa, input logic [31:0] aa);
        @(negedge clk);
        sync_ev = sev; async_ev = aev; sync_vaddr = sa; async_vaddr = aa;
        @(negedge clk);
        sync_ev = '0; async_ev = '0;
    endtask

    task automatic rd_ev(input logic [1:0] sel, input logic [15:0] sev,
                         input logic [7:0] aev, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel; sync_ev = sev; async_ev = aev;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; sync_ev = '0; async_ev = '0;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check("R10 irq", {31'b0, irq}, 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd_ev(2'(s), '0, '0, d);
            check("R10 reg", d, 32'h0);
        end

        // table walk
        for (int i = 0; i < 13; i++) begin
            pulse(VEC[i].sev, VEC[i].aev, VEC[i].sa, VEC[i].aa);
            rd_ev(VEC[i].sel, '0, '0, d);
            check($sformatf("R1/R2/R4/R5/R6/R7 row %0d", i), d, VEC[i].exp);
        end

        // R11 no read -> zero
        pulse(16'h0040, 8'h00, 32'h5000, 32'h0);
        @(negedge clk); #1;
        check("R11 idle", rd_data, 32'h0);

        // R8 same-cycle event and read
        rd_ev(2'd0, 16'h0020, 8'h00, d);
        check("R8 pre-value", d, 32'h0040);
        rd_ev(2'd0, '0, '0, d);
        check("R8 survivor", d, 32'h0020);

        // R3 reading one register leaves the other
        pulse(16'h0000, 8'h20, 32'h0, 32'hD000);
        rd_ev(2'd0, '0, '0, d);
        check("R3 sync read", d, 32'h0020);
        check("R9 irq held", {31'b0, irq}, 32'h1);
        rd_ev(2'd2, '0, '0, d);
        check("R3 async kept", d, 32'h0020);
        check("R9 irq falls", {31'b0, irq}, 32'h0);

        // R9 read colliding with new async event
        pulse(16'h0000, 8'h10, 32'h0, 32'hE000);
        check("R9 irq rises", {31'b0, irq}, 32'h1);
        rd_ev(2'd2, '0, 8'h80, d);
        check("R9 read value", d, 32'h0010);
        check("R9 irq stays", {31'b0, irq}, 32'h1);
        rd_ev(2'd2, '0, '0, d);
        check("R8 async survivor", d, 32'h0080);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        rd_ev(2'd0, '0, '0, d);
        check("R5 both mirrored", d, 32'h0090);
        rd_ev(2'd1, '0, '0, d);
        check("R7 sync addr untouched by async", d, 32'h5000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule